// File: doc/BRIEF.md
# Static Crossbar Route Sequencer

This block steps through a program of 64-bit instructions and drives a tile's static crossbar with it. The crossbar has five word-wide input queues and five output queues: north, east, south, west and the local processor. Every instruction has two halves that act in the same cycle. A control half performs a move into one of four registers, a conditional branch, a jump or nothing. A route half connects any input to any set of outputs. The instruction store sits outside the block. The sequencer presents a fetch address and reads the addressed word combinationally in the same cycle.

An instruction issues only when every input queue it names holds data and every output queue it names has room. If any one of them fails, nothing happens in that cycle: no queue is dequeued, no output is pushed, no register is written and the fetch address does not move. Each control transfer has one delay slot, and the slot always executes. A sequencer with two states tracks the slot:
- ST_STEP: the next address is the current address plus one.
- ST_SLOT: the instruction being executed is a delay slot, and the next address is the saved target.

The transitions are:
- STEP_TO_SLOT: an issued instruction transfers control.
- SLOT_TO_SLOT: a transfer issues inside a delay slot.
- SLOT_TO_STEP and STEP_TO_STEP: an issued instruction does not transfer control.
- A stall keeps the current state.

Port indices are N=0, E=1, S=2, W=3, P=4. Data buses are the five words packed with index 0 in the low word.

Top module: `xbar_route_seq`

## Requirements
- R1: While reset is low, in_deq and out_push are zero. After reset the fetch address is 0 and all four registers read zero.
- R2: Route fields are 3-bit selectors: N output in bits [2:0], E in [5:3], S in [8:6], W in [11:9], P in [14:12]. Codes 1..5 select input N, E, S, W, P. When an instruction issues, each output with a selector in 1..5 is pushed with the selected input's word.
- R3: One input may feed several outputs in the same cycle, and several routes may run at once. Each consumed input is dequeued exactly once.
- R4: If any named input is not valid, or any named output is full, the whole instruction stalls. There is no dequeue, no push and no register write, and the fetch address holds.
- R5: Selector codes 0, 6 and 7 name nothing. The full state of an unnamed output and the valid state of an unused input have no effect.
- R6: An issued instruction dequeues exactly the inputs it names and pushes exactly the outputs it names. In ST_STEP it advances the fetch address by one.
- R7: Opcode bits [63:60] decode as: 1 = move, 2 = branch if zero, 3 = branch if nonzero, 4 = jump to immediate, 5 = jump to source. Every other value is a nop. A move writes register bits [59:58] with its source. Source field [57:54] selects a register [55:54] when bit 57 is 0, or an input port by route code [56:54] when bit 57 is 1. A port source is a named input for stall and dequeue.
- R8: The two conditional branches test the source value for zero and for nonzero, and jump to the immediate [39:24] when the test holds.
- R9: A jump takes its target from the immediate or from the source value. A port used as the source can also be routed onward in the same cycle.
- R10: After a taken transfer, the next sequential instruction always executes as a delay slot, then fetch continues at the target. A transfer taken inside a slot starts a new slot after the pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PCW | Fetch address |
| imem_data | input | 64 | Instruction at imem_addr, same cycle |
| in_data | input | 5*DW | Head words of the five input queues |
| in_valid | input | 5 | Input queue not empty |
| in_deq | output | 5 | Pop the input queue this cycle |
| out_data | output | 5*DW | Words for the five output queues |
| out_push | output | 5 | Push the output queue this cycle |
| out_full | input | 5 | Output queue has no room |

## Verification
The route half is combinational from the fetched word and the queue flags. in_deq, out_push and out_data therefore belong to the cycle in which the instruction is presented, and the bench samples them one time unit after applying inputs, before the next edge. Register writes and address changes land on the next edge, so the bench checks the fetch address one unit after that edge. Register contents are read back by jumping through a register and watching the address that follows.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
    localparam int NPORT = 5;
    localparam int SELW  = 3;
    localparam int IW    = 64;
    localparam int REGN  = 4;

    typedef enum logic [2:0] {
        OP_NOP, OP_MOVE, OP_BEQZ, OP_BNEZ, OP_JUMP, OP_JREG
    } op_e;

    typedef enum logic {
        ST_STEP, ST_SLOT
    } seq_e;

    function automatic logic [NPORT-1:0] sel_mask(input logic [SELW-1:0] code);
        logic [NPORT-1:0] m;
        m = '0;
        if (code >= 3'd1 && code <= 3'd5) m[code - 3'd1] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/xrs_decode.sv
module xrs_decode
    import xrs_pkg::*;
(
    input  logic [IW-1:0]         instr,
    output op_e                   op,
    output logic [1:0]            rd,
    output logic                  src_is_port,
    output logic [1:0]            src_reg,
    output logic [NPORT-1:0]      src_mask,
    output logic [15:0]           imm,
    output logic [NPORT*SELW-1:0] sel,
    output logic [NPORT-1:0]      need_in,
    output logic [NPORT-1:0]      need_out
);
    logic uses_src;
    logic unused_bits;

    assign unused_bits = ^{instr[53:40], instr[23:15]};

    always_comb begin
        unique case (instr[63:60])
            4'd1:    op = OP_MOVE;
            4'd2:    op = OP_BEQZ;
            4'd3:    op = OP_BNEZ;
            4'd4:    op = OP_JUMP;
            4'd5:    op = OP_JREG;
            default: op = OP_NOP;
        endcase
        rd          = instr[59:58];
        src_is_port = instr[57];
        src_reg     = instr[55:54];
        imm         = instr[39:24];
        sel         = instr[NPORT*SELW-1:0];
        uses_src    = (op == OP_MOVE) || (op == OP_BEQZ) ||
                      (op == OP_BNEZ) || (op == OP_JREG);
        src_mask    = (uses_src && src_is_port) ? sel_mask(instr[56:54]) : '0;
        need_in     = src_mask;
        for (int k = 0; k < NPORT; k++) begin
            need_in     = need_in | sel_mask(sel[k*SELW +: SELW]);
            need_out[k] = |sel_mask(sel[k*SELW +: SELW]);
        end
    end
endmodule

// File: rtl/xrs_crossbar.sv
module xrs_crossbar
    import xrs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NPORT*DW-1:0]   in_data,
    input  logic [NPORT*SELW-1:0] sel,
    output logic [NPORT*DW-1:0]   out_data
);
    for (genvar k = 0; k < NPORT; k++) begin : g_out
        logic [DW-1:0] pick;
        always_comb begin
            pick = '0;
            for (int j = 0; j < NPORT; j++) begin
                if (sel[k*SELW +: SELW] == SELW'(j + 1)) pick = in_data[j*DW +: DW];
            end
        end
        assign out_data[k*DW +: DW] = pick;
    end
endmodule

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
    import xrs_pkg::*;
#(
    parameter int DW  = 32,
    parameter int PCW = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  op_e                op,
    input  logic [1:0]         rd,
    input  logic               src_is_port,
    input  logic [1:0]         src_reg,
    input  logic [NPORT-1:0]   src_mask,
    input  logic [15:0]        imm,
    input  logic [NPORT*DW-1:0] in_data,
    output logic [PCW-1:0]     pc,
    output seq_e               state
);
    logic [DW-1:0]  regs [REGN];
    logic [PCW-1:0] pc_q, pc_d, tgt_q, tgt_d, target;
    seq_e           st_q, st_d;
    logic [DW-1:0]  val;
    logic           taken, wr_en;
    logic           unused_imm;

    assign unused_imm = ^imm;

    always_comb begin
        val = '0;
        if (src_is_port) begin
            for (int k = 0; k < NPORT; k++)
                if (src_mask[k]) val = val | in_data[k*DW +: DW];
        end else begin
            val = regs[src_reg];
        end
        unique case (op)
            OP_BEQZ: begin taken = (val == '0); target = imm[PCW-1:0]; end
            OP_BNEZ: begin taken = (val != '0); target = imm[PCW-1:0]; end
            OP_JUMP: begin taken = 1'b1;        target = imm[PCW-1:0]; end
            OP_JREG: begin taken = 1'b1;        target = val[PCW-1:0]; end
            default: begin taken = 1'b0;        target = imm[PCW-1:0]; end
        endcase
        wr_en = go && (op == OP_MOVE);
        pc_d  = pc_q;
        tgt_d = tgt_q;
        st_d  = st_q;
        if (go) begin
            unique case (st_q)
                ST_STEP: pc_d = pc_q + {{(PCW-1){1'b0}}, 1'b1};
                ST_SLOT: pc_d = tgt_q;
                default: pc_d = pc_q;
            endcase
            st_d = taken ? ST_SLOT : ST_STEP;
            if (taken) tgt_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            tgt_q <= '0;
            st_q  <= ST_STEP;
            for (int r = 0; r < REGN; r++) regs[r] <= '0;
        end else begin
            pc_q  <= pc_d;
            tgt_q <= tgt_d;
            st_q  <= st_d;
            if (wr_en) regs[rd] <= val;
        end
    end

    always_comb begin
        pc    = pc_q;
        state = st_q;
    end
endmodule

// File: rtl/xbar_route_seq.sv
module xbar_route_seq
    import xrs_pkg::*;
#(
    parameter int DW  = 32,
    parameter int PCW = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [PCW-1:0]      imem_addr,
    input  logic [IW-1:0]       imem_data,
    input  logic [NPORT*DW-1:0] in_data,
    input  logic [NPORT-1:0]    in_valid,
    output logic [NPORT-1:0]    in_deq,
    output logic [NPORT*DW-1:0] out_data,
    output logic [NPORT-1:0]    out_push,
    input  logic [NPORT-1:0]    out_full
);
    localparam int RW = NPORT * SELW;

    op_e              op;
    logic [1:0]       rd, src_reg;
    logic             src_is_port;
    logic [NPORT-1:0] src_mask, need_in, need_out;
    logic [15:0]      imm;
    logic [RW-1:0]    sel;
    logic             stall, go;
    seq_e             seq_state;

    xrs_decode u_dec (
        .instr(imem_data), .op(op), .rd(rd), .src_is_port(src_is_port),
        .src_reg(src_reg), .src_mask(src_mask), .imm(imm), .sel(sel),
        .need_in(need_in), .need_out(need_out)
    );

    assign stall    = (|(need_in & ~in_valid)) || (|(need_out & out_full));
    assign go       = rst_n && !stall;
    assign in_deq   = go ? need_in  : '0;
    assign out_push = go ? need_out : '0;

    xrs_crossbar #(.DW(DW)) u_xbar (
        .in_data(in_data), .sel(sel), .out_data(out_data)
    );

    xrs_ctrl #(.DW(DW), .PCW(PCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .rd(rd),
        .src_is_port(src_is_port), .src_reg(src_reg), .src_mask(src_mask),
        .imm(imm), .in_data(in_data), .pc(imem_addr), .state(seq_state)
    );
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk
    import xrs_pkg::*;
#(
    parameter int PCW = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] in_valid,
    input logic [NPORT-1:0] in_deq,
    input logic [NPORT-1:0] out_full,
    input logic [NPORT-1:0] out_push,
    input logic [PCW-1:0]   imem_addr,
    input logic             go,
    input seq_e             seq_state
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (in_deq == '0 && out_push == '0));

    // R4
    no_deq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_deq & ~in_valid) == '0);

    // R4
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push & out_full) == '0);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(imem_addr));

    // R6
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && seq_state == ST_STEP) |=>
            imem_addr == $past(imem_addr) + {{(PCW-1){1'b0}}, 1'b1});
endmodule

bind xbar_route_seq xrs_chk #(.PCW(PCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_deq(in_deq),
    .out_full(out_full), .out_push(out_push), .imem_addr(imem_addr),
    .go(go), .seq_state(seq_state)
);

// File: tb/test_xbar_route_seq.sv
module test_xbar_route_seq;
    localparam int DW = 32;
    localparam int PCW = 13;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PCW-1:0]  imem_addr;
    logic [63:0]     imem_data;
    logic [5*DW-1:0] in_data, out_data;
    logic [4:0]      in_valid, in_deq, out_push, out_full;
    logic            use_prog;
    logic [63:0]     vec_instr;
    logic [63:0]     prog [16];
    int              n_chk = 0, n_bad = 0;
    logic [PCW-1:0]  exp_pc;

    always #2 clk = ~clk;

    assign imem_data = use_prog ? prog[imem_addr[3:0]] : vec_instr;

    xbar_route_seq #(.DW(DW), .PCW(PCW)) i_xbar_route_seq (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .in_data(in_data), .in_valid(in_valid), .in_deq(in_deq),
        .out_data(out_data), .out_push(out_push), .out_full(out_full)
    );

    // {route[14:0], valid, full, exp_deq, exp_push, issues}
    localparam logic [35:0] VEC [10] = '{
        {15'o00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b1},
        {15'o00100, 5'b00001, 5'b00000, 5'b00001, 5'b00100, 1'b1},
        {15'o00100, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b0},
        {15'o10100, 5'b00001, 5'b10000, 5'b00000, 5'b00000, 1'b0},
        {15'o10100, 5'b00001, 5'b00000, 5'b00001, 5'b10100, 1'b1},
        {15'o15140, 5'b11001, 5'b00000, 5'b11001, 5'b11110, 1'b1},
        {15'o15140, 5'b10001, 5'b00000, 5'b00000, 5'b00000, 1'b0},
        {15'o00010, 5'b00001, 5'b00100, 5'b00001, 5'b00010, 1'b1},
        {15'o00076, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 1'b1},
        {15'o00305, 5'b10100, 5'b00000, 5'b10100, 5'b00101, 1'b1}
    };

    // {pc, exp_deq, exp_push}
    localparam logic [22:0] STEPS [11] = '{
        {13'd0,  5'b01000, 5'b00000},
        {13'd1,  5'b00001, 5'b00010},
        {13'd2,  5'b00000, 5'b00000},
        {13'd6,  5'b00000, 5'b00000},
        {13'd7,  5'b00000, 5'b00000},
        {13'd9,  5'b00000, 5'b00000},
        {13'd10, 5'b00010, 5'b10000},
        {13'd11, 5'b00000, 5'b00000},
        {13'd14, 5'b00000, 5'b00000},
        {13'd3,  5'b00000, 5'b00000},
        {13'd4,  5'b00000, 5'b00000}
    };

    function automatic logic [63:0] mk(input logic [3:0] op, input logic [1:0] rd,
                                       input logic [3:0] src, input logic [15:0] imm,
                                       input logic [14:0] route);
        return {op, rd, src, 14'd0, imm, 9'd0, route};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; use_prog = 1'b0; in_valid = '0; out_full = '0;
        for (int k = 0; k < 5; k++) in_data[k*DW +: DW] = 32'h1000_0000 * (k + 1) + k;
        for (int a = 0; a < 16; a++) prog[a] = '0;
        // reset with a routing, port-sourced move presented and all inputs valid
        vec_instr = mk(4'd1, 2'd2, 4'b1001, 16'd0, 15'o00100);
        in_valid  = 5'b11111;
        tick(); tick();
        check("R1 deq in reset", 64'(in_deq), 64'd0);
        check("R1 push in reset", 64'(out_push), 64'd0);
        check("R1 addr in reset", 64'(imem_addr), 64'd0);
        vec_instr = '0; in_valid = '0;
        rst_n = 1'b1;
        #1;
        exp_pc = '0;

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 10; i++) begin
            logic [14:0] rt;
            rt        = VEC[i][35:21];
            vec_instr = mk(4'd0, 2'd0, 4'd0, 16'd0, rt);
            in_valid  = VEC[i][20:16];
            out_full  = VEC[i][15:11];
            #1;
            check($sformatf("R4/R6 deq vec%0d", i), 64'(in_deq), 64'(VEC[i][10:6]));
            check($sformatf("R3/R5 push vec%0d", i), 64'(out_push), 64'(VEC[i][5:1]));
            check($sformatf("R6 addr vec%0d", i), 64'(imem_addr), 64'(exp_pc));
            for (int k = 0; k < 5; k++) begin
                logic [2:0] c;
                c = rt[k*3 +: 3];
                if (VEC[i][1 + k] && c >= 3'd1 && c <= 3'd5)
                    check($sformatf("R2 data vec%0d out%0d", i, k),
                          64'(out_data[k*DW +: DW]), 64'(in_data[(c - 1)*DW +: DW]));
            end
            tick();
            if (VEC[i][0]) exp_pc = exp_pc + 1'b1;
        end
        check("R4/R6 addr after table", 64'(imem_addr), 64'(exp_pc));

        // program: R7 R8 R9 R10
        prog[0]  = mk(4'd1, 2'd1, 4'b1100, 16'd0, 15'o00000);  // move r1 <- W
        prog[1]  = mk(4'd2, 2'd0, 4'b1001, 16'd6, 15'o00010);  // beqz N, 6 ; N->E
        prog[6]  = mk(4'd5, 2'd0, 4'b0001, 16'd0, 15'o00000);  // jr r1
        prog[9]  = mk(4'd3, 2'd0, 4'b0000, 16'd2, 15'o00000);  // bnez r0, 2
        prog[10] = mk(4'd5, 2'd0, 4'b1010, 16'd0, 15'o20000);  // jr E ; E->P
        prog[11] = mk(4'd4, 2'd0, 4'b0000, 16'd3, 15'o00000);  // j 3 in slot
        in_data  = {32'd21, 32'd9, 32'd33, 32'd14, 32'd0};
        out_full = '0; in_valid = '0;
        rst_n = 1'b0; use_prog = 1'b1;
        tick();
        rst_n = 1'b1;
        #1;
        // control source port empty -> stall (R4, R7)
        check("R4 src-port stall deq", 64'(in_deq), 64'd0);
        tick();
        check("R4 src-port stall addr", 64'(imem_addr), 64'd0);
        in_valid = 5'b11111;
        for (int s = 0; s < 11; s++) begin
            #1;
            check($sformatf("R10 addr step%0d", s), 64'(imem_addr), 64'(STEPS[s][22:10]));
            check($sformatf("R7 deq step%0d", s), 64'(in_deq), 64'(STEPS[s][9:5]));
            check($sformatf("R9 push step%0d", s), 64'(out_push), 64'(STEPS[s][4:0]));
            if (s == 1) check("R8 beqz routes N to E", 64'(out_data[1*DW +: DW]), 64'd0);
            if (s == 6) check("R9 jr port value routed to P", 64'(out_data[4*DW +: DW]), 64'd14);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule